// File: doc/BRIEF.md
# Gated Divided Clock Output Stage

This block produces one output clock from either of two running source clocks: a PLL clock or a crystal/external reference clock. The chosen source passes through a power-of-two divider and then through an enable gate. The gate is controlled by an active-low pin. Static configuration bits set the source, the divide ratio, and what the pin means. In output-enable mode the pin only gates the output. In power-down mode the pin also asks the analog blocks to stop, and after they restart the output waits out a relock period.

Disabling can be immediate (asynchronous) or can wait for the output's own falling edge. Re-enabling always waits for a falling edge of the divided clock, so the first pulse after an enable always has full width. While disabled, the output is reported as not driven and is held low. The source and the divide code may only be changed while the output is disabled.

Top module: `clkout_gate_top`

## Requirements
- R1: `div_code` value k (0 to 7) sets the output period to 2^k periods of the selected source (ratios 1, 2, 4, 8, 16, 32, 64, 128).
- R2: `src_sel` = 0 selects `ref_clk` as the source and `src_sel` = 1 selects `pll_clk`.
- R3: While `rst` is high, `clk_out`, `clk_oe` and `pd_req` are all low.
- R4: Whenever `clk_oe` is low, `clk_out` is low.
- R5: With `dis_async` = 0, a falling `pin_n` lets the current high pulse of `clk_out` finish at full width. After that pulse, `clk_oe` and `clk_out` stay low while `pin_n` is low.
- R6: With `dis_async` = 1, `clk_oe` and `clk_out` go low within combinational delay of `pin_n` going low, whatever the output level.
- R7: After `pin_n` returns high, the output restarts at a falling boundary of the divided clock, so the first high pulse has full width (half the output period).
- R8: With `pin_mode` = 0 (output-enable mode), `pd_req` stays low.
- R9: With `pin_mode` = 1 (power-down mode), `pd_req` is high within 3 `ref_clk` cycles of `pin_n` going low. It is low within 3 cycles of `pin_n` returning high.
- R10: In power-down mode, after `pin_n` returns high, `clk_oe` stays low for at least `RELOCK_CYCLES` `ref_clk` cycles. It rises within `RELOCK_CYCLES` + 40 cycles when the ratio is 2.
- R11: `clk_oe` never rises while `pd_req` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Crystal or external reference clock; also clocks the relock timer |
| pll_clk | input | 1 | PLL clock |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| pin_n | input | 1 | Active-low control pin |
| src_sel | input | 1 | Source select: 0 reference, 1 PLL |
| div_code | input | 3 | Divide code k, ratio 2^k |
| pin_mode | input | 1 | 0 output-enable mode, 1 power-down mode |
| dis_async | input | 1 | 1 immediate disable, 0 disable at the output's falling edge |
| clk_out | output | 1 | Gated, divided output clock; low when not enabled |
| clk_oe | output | 1 | Output driver enable; low means the output is tri-stated |
| pd_req | output | 1 | Request for the PLL and oscillator to power down |

## Verification
Four properties are checked on every reference cycle:
- The output is low whenever its enable is low.
- `pd_req` never appears in output-enable mode.
- An immediate disable holds while the pin is low.
- The enable never rises during a power-down request.

The directed scenarios cover the behaviour that depends on timing and that no single-cycle property can capture:
- the measured period for each divide code and both sources;
- the full width of the last pulse before a synchronous disable;
- the full width of the first pulse after re-enable;
- the length of the relock window after power-down.

// File: rtl/clkout_gate_pkg.sv
`timescale 1ns/1ps
package clkout_gate_pkg;

    localparam int CNT_W = 7;

    typedef enum logic {
        SRC_REF = 1'b0,
        SRC_PLL = 1'b1
    } src_sel_e;

    typedef enum logic {
        PIN_AS_OE    = 1'b0,
        PIN_AS_PWRDN = 1'b1
    } pin_mode_e;

    typedef enum logic {
        DIS_AT_FALL = 1'b0,
        DIS_AT_ONCE = 1'b1
    } dis_mode_e;

    typedef struct packed {
        src_sel_e  src;
        logic [2:0] code;
        pin_mode_e mode;
        dis_mode_e dis;
    } gate_cfg_t;

    // Divided clock level for code k >= 1: counter bit k-1.
    function automatic logic div_tap(input logic [CNT_W-1:0] cnt,
                                     input logic [2:0] code);
        logic [2:0] idx;
        idx = code - 3'd1;
        if (code == 3'd0) return 1'b0;
        return cnt[idx];
    endfunction

endpackage

// File: rtl/bit_sync.sv
`timescale 1ns/1ps
module bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/relock_timer.sv
`timescale 1ns/1ps
module relock_timer #(
    parameter int RELOCK_CYCLES = 1024
) (
    input  logic ref_clk,
    input  logic rst,
    input  logic pwrdn_mode,
    input  logic pin_ok,
    output logic pd_req,
    output logic ready
);
    localparam int TW = $clog2(RELOCK_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(RELOCK_CYCLES - 1);

    logic [TW-1:0] cnt;
    logic          busy;
    logic          down;

    assign down = pwrdn_mode & ~pin_ok;

    always_ff @(posedge ref_clk) begin
        if (rst) begin
            cnt    <= '0;
            busy   <= 1'b0;
            pd_req <= 1'b0;
        end else begin
            pd_req <= down;
            if (down) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                if (cnt == LAST) busy <= 1'b0;
                else             cnt  <= cnt + 1'b1;
            end
        end
    end

    assign ready = ~busy & ~down;
endmodule

// File: rtl/div_gate.sv
`timescale 1ns/1ps
module div_gate
    import clkout_gate_pkg::*;
(
    input  logic       src_clk,
    input  logic       rst,
    input  logic [2:0] code,
    input  logic       dis_async,
    input  logic       en_want,
    input  logic       kill_now,
    output logic       clk_out,
    output logic       clk_oe
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             fall_evt;
    logic             gate_p;
    logic             gate_n;
    logic             gate;
    logic             lvl;

    assign cnt_nxt  = cnt + 1'b1;
    assign fall_evt = div_tap(cnt, code) & ~div_tap(cnt_nxt, code);

    always_ff @(posedge src_clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    // Gate for ratios 2..128: updated only as the divided clock goes low.
    always_ff @(posedge src_clk) begin
        if (rst)                      gate_p <= 1'b0;
        else if (dis_async & ~en_want) gate_p <= 1'b0;
        else if (fall_evt)            gate_p <= en_want;
    end

    // Gate for ratio 1: updated at the falling edge of the source itself.
    always_ff @(negedge src_clk) begin
        if (rst) gate_n <= 1'b0;
        else     gate_n <= en_want;
    end

    assign gate    = (code == 3'd0) ? gate_n : gate_p;
    assign lvl     = (code == 3'd0) ? src_clk : div_tap(cnt, code);
    assign clk_oe  = gate & ~kill_now;
    assign clk_out = lvl & clk_oe;
endmodule

// File: rtl/clkout_gate_top.sv
`timescale 1ns/1ps
module clkout_gate_top
    import clkout_gate_pkg::*;
#(
    parameter int RELOCK_CYCLES = 1024,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       ref_clk,
    input  logic       pll_clk,
    input  logic       rst,
    input  logic       pin_n,
    input  logic       src_sel,
    input  logic [2:0] div_code,
    input  logic       pin_mode,
    input  logic       dis_async,
    output logic       clk_out,
    output logic       clk_oe,
    output logic       pd_req
);
    gate_cfg_t cfg;
    logic src_clk;
    logic pin_ref_s;
    logic pin_src_s;
    logic ready_ref;
    logic ready_src;
    logic en_want;
    logic kill_now;

    assign cfg.src  = src_sel_e'(src_sel);
    assign cfg.code = div_code;
    assign cfg.mode = pin_mode_e'(pin_mode);
    assign cfg.dis  = dis_mode_e'(dis_async);

    // Static select; changed only while the output is disabled.
    assign src_clk = (cfg.src == SRC_PLL) ? pll_clk : ref_clk;

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_ref (
        .clk(ref_clk), .rst(rst), .d(pin_n), .q(pin_ref_s)
    );

    relock_timer #(.RELOCK_CYCLES(RELOCK_CYCLES)) u_relock (
        .ref_clk    (ref_clk),
        .rst        (rst),
        .pwrdn_mode (cfg.mode == PIN_AS_PWRDN),
        .pin_ok     (pin_ref_s),
        .pd_req     (pd_req),
        .ready      (ready_ref)
    );

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pin_src (
        .clk(src_clk), .rst(rst), .d(pin_n), .q(pin_src_s)
    );

    bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_src (
        .clk(src_clk), .rst(rst), .d(ready_ref), .q(ready_src)
    );

    assign en_want  = pin_src_s & ready_src;
    assign kill_now = (cfg.dis == DIS_AT_ONCE) & ~pin_n;

    div_gate u_gate (
        .src_clk   (src_clk),
        .rst       (rst),
        .code      (cfg.code),
        .dis_async (cfg.dis == DIS_AT_ONCE),
        .en_want   (en_want),
        .kill_now  (kill_now),
        .clk_out   (clk_out),
        .clk_oe    (clk_oe)
    );
endmodule

// File: rtl/clkout_gate_chk.sv
`timescale 1ns/1ps
module clkout_gate_chk (
    input logic ref_clk,
    input logic rst,
    input logic pin_n,
    input logic pin_mode,
    input logic dis_async,
    input logic clk_out,
    input logic clk_oe,
    input logic pd_req
);
    // R4
    out_low_when_off_chk: assert property (@(posedge ref_clk) disable iff (rst)
        !clk_oe |-> !clk_out);

    // R8
    no_pd_in_oe_mode_chk: assert property (@(posedge ref_clk) disable iff (rst)
        !pin_mode |-> !pd_req);

    // R6
    async_off_chk: assert property (@(posedge ref_clk) disable iff (rst)
        (dis_async && !pin_n) |-> !clk_oe);

    // R11
    no_enable_in_pd_chk: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(clk_oe) |-> !pd_req);
endmodule

bind clkout_gate_top clkout_gate_chk u_chk (
    .ref_clk   (ref_clk),
    .rst       (rst),
    .pin_n     (pin_n),
    .pin_mode  (pin_mode),
    .dis_async (dis_async),
    .clk_out   (clk_out),
    .clk_oe    (clk_oe),
    .pd_req    (pd_req)
);

// File: tb/clkout_gate_top_tb.sv
`timescale 1ns/1ps
module clkout_gate_top_tb;
    localparam real REF_P = 8.0;
    localparam real PLL_P = 6.0;
    localparam int  RELOCK = 1024;

    logic ref_clk = 1'b0;
    logic pll_clk = 1'b0;
    logic rst = 1'b1;
    logic pin_n = 1'b1;
    logic src_sel = 1'b0;
    logic [2:0] div_code = 3'd1;
    logic pin_mode = 1'b0;
    logic dis_async = 1'b0;
    logic clk_out, clk_oe, pd_req;

    int checks = 0;
    int errors = 0;

    always #(REF_P/2) ref_clk = ~ref_clk;
    always #(PLL_P/2) pll_clk = ~pll_clk;

    clkout_gate_top u_dut (
        .ref_clk(ref_clk), .pll_clk(pll_clk), .rst(rst), .pin_n(pin_n),
        .src_sel(src_sel), .div_code(div_code), .pin_mode(pin_mode),
        .dis_async(dis_async), .clk_out(clk_out), .clk_oe(clk_oe), .pd_req(pd_req)
    );

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_time(string req, realtime act, realtime exp);
        checks++;
        if (act < exp - 0.01 || act > exp + 0.01) begin
            errors++;
            $display("FAIL %s: got %0.3f ns expected %0.3f ns", req, act, exp);
        end
    endtask

    task automatic wait_ref(int n);
        repeat (n) @(negedge ref_clk);
    endtask

    task automatic disable_out();
        @(negedge ref_clk);
        pin_n = 1'b0;
        for (int i = 0; i < 3000 && clk_oe; i++) @(negedge ref_clk);
        wait_ref(4);
    endtask

    task automatic t_reset();
        wait_ref(3);
        check_bit("R3 clk_out in reset", clk_out, 1'b0);
        check_bit("R3 clk_oe in reset", clk_oe, 1'b0);
        check_bit("R3 pd_req in reset", pd_req, 1'b0);
        wait_ref(8);
        rst = 1'b0;
        wait_ref(4);
    endtask

    task automatic t_ratio(logic src, logic [2:0] code, string req);
        realtime t0, t1;
        real per;
        disable_out();
        src_sel = src;
        div_code = code;
        wait_ref(4);
        pin_n = 1'b1;
        @(posedge clk_out);
        @(posedge clk_out);
        t0 = $realtime;
        @(posedge clk_out);
        t1 = $realtime;
        per = src ? PLL_P : REF_P;
        check_time(req, t1 - t0, per * (1 << code));
    endtask

    task automatic t_sync_disable();
        realtime tr, tf;
        disable_out();
        src_sel = 1'b0; div_code = 3'd4; dis_async = 1'b0; pin_mode = 1'b0;
        wait_ref(2);
        pin_n = 1'b1;
        @(posedge clk_out);
        @(posedge clk_out);
        tr = $realtime;
        #10;
        pin_n = 1'b0;
        @(negedge clk_out);
        tf = $realtime;
        check_time("R5 last pulse full width", tf - tr, REF_P * 8);
        wait_ref(40);
        check_bit("R5 oe off after sync disable", clk_oe, 1'b0);
        check_bit("R5 out low after sync disable", clk_out, 1'b0);
        check_bit("R8 pd_req low in oe mode", pd_req, 1'b0);
        pin_n = 1'b1;
        @(posedge clk_out);
        tr = $realtime;
        @(negedge clk_out);
        tf = $realtime;
        check_time("R7 first pulse full width", tf - tr, REF_P * 8);
    endtask

    task automatic t_async_disable();
        realtime tr, tf;
        disable_out();
        src_sel = 1'b0; div_code = 3'd4; dis_async = 1'b1;
        wait_ref(2);
        pin_n = 1'b1;
        @(posedge clk_out);
        @(posedge clk_out);
        #10;
        pin_n = 1'b0;
        #1;
        check_bit("R6 out off at once", clk_out, 1'b0);
        check_bit("R6 oe off at once", clk_oe, 1'b0);
        wait_ref(40);
        check_bit("R4 out low while oe low", clk_out, 1'b0);
        pin_n = 1'b1;
        @(posedge clk_out);
        tr = $realtime;
        @(negedge clk_out);
        tf = $realtime;
        check_time("R7 first pulse after async", tf - tr, REF_P * 8);
        dis_async = 1'b0;
    endtask

    task automatic t_ratio1_pll();
        realtime tr, tf;
        disable_out();
        src_sel = 1'b1; div_code = 3'd0;
        wait_ref(2);
        pin_n = 1'b1;
        @(posedge clk_out);
        @(posedge clk_out);
        tr = $realtime;
        @(negedge clk_out);
        tf = $realtime;
        check_time("R7 ratio 1 pulse width", tf - tr, PLL_P / 2);
        disable_out();
        wait_ref(5);
        check_bit("R5 ratio 1 stays off", clk_out, 1'b0);
    endtask

    task automatic t_powerdown();
        disable_out();
        src_sel = 1'b0; div_code = 3'd1; pin_mode = 1'b1;
        wait_ref(4);
        check_bit("R9 pd_req high while pin low", pd_req, 1'b1);
        pin_n = 1'b1;
        wait_ref(4);
        check_bit("R9 pd_req low after pin high", pd_req, 1'b0);
        check_bit("R10 oe held during relock", clk_oe, 1'b0);
        wait_ref(RELOCK - 10);
        check_bit("R10 oe still off near relock end", clk_oe, 1'b0);
        wait_ref(46);
        check_bit("R10 oe on after relock", clk_oe, 1'b1);
        pin_mode = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        for (int k = 0; k < 8; k++) t_ratio(1'b0, 3'(k), "R1 ratio on reference source");
        t_ratio(1'b1, 3'd3, "R2 pll source ratio 8");
        t_ratio(1'b1, 3'd5, "R2 pll source ratio 32");
        t_sync_disable();
        t_async_disable();
        t_ratio1_pll();
        t_powerdown();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule